// File: doc/BRIEF.md
# Eight-Pin General Purpose I/O Port Controller

This block controls one port of general purpose pins. Each pin has four configuration bits: a direction bit, an alternate-function select bit, a port data bit and an analog-disable bit. Each pin also has a change-interrupt enable bit. From these bits the block drives the pad output value, the pad output enable and the pad pull-up enable. When a pin is an output, the block either drives the port data bit or passes through an output from a peripheral. When a pin is an input, the port data bit is reused to switch its pull-up on or off.

The pad input goes through a two-stage synchronizer and is then read through a read-only pin register. A pin whose analog-disable bit is set reads as 0. Each enabled pin compares its synchronized level with the level captured at the most recent pin-register read. A difference sets a sticky per-pin flag, and all flags are ORed into one interrupt request. A read of the pin register takes a new snapshot of the levels and clears the flags. The read therefore both acknowledges the interrupt and arms detection again.

Registers are written through a select/data strobe and read through a combinational read mux. The select codes are: 0 direction, 1 alternate, 2 port data, 3 analog-disable, 4 change enable, 5 pin (read-only).

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all configuration registers are 0: pad_oe_o, pad_pu_o and pad_out_o are 0 and irq_o is low.
- R2: One cycle after a write with select 0, pad_oe_o equals the written value (1 = output, 0 = input).
- R3: For an output pin with its alternate bit (select 1) at 0, pad_out_o carries the port data bit (select 2).
- R4: For an output pin with its alternate bit at 1, pad_out_o carries the matching periph_out_i bit.
- R5: pad_pu_o of a pin equals its port data bit when the pin is an input, and is 0 when the pin is an output.
- R6: With select 5, rd_data_o shows the pad level of each pin two clock edges after the pad changes, and not after one edge.
- R7: A pin whose analog-disable bit (select 3) is 1 reads as 0 in the pin register, whatever its pad level.
- R8: If a pin's change-enable bit (select 4) is 1 and its synchronized level differs from the last snapshot, irq_o goes high one edge after the new level shows in the pin register. Rising and falling changes both count, and irq_o is the OR over all pins.
- R9: A read strobe with select 5 snapshots the pin levels and clears every pending change flag, so irq_o is low in the following cycle.
- R10: A level change on a pin whose change-enable bit is 0 does not raise irq_o.
- R11: Registers 0 to 4 read back the last value written. A write to select 5 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | 8 | Write data, one bit per pin |
| rd_en_i | input | 1 | Read strobe; with select 5 it acknowledges changes |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | 8 | Combinational read data |
| pad_in_i | input | 8 | Asynchronous pad input levels |
| periph_out_i | input | 8 | Peripheral output values for alternate use |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| pad_pu_o | output | 8 | Pad pull-up enables |
| irq_o | output | 1 | Change interrupt request |

## Verification
The output mux is driven with all pins as outputs using plain port data, and then with a mixed alternate mask over a distinct peripheral pattern, so that the two data sources produce different bits. Pull-ups are checked with half the pins as inputs, so that a pull-up leaking onto an output pin would show. The pad level is sampled after one edge and after two edges, which separates correct synchronizer depth from too few stages. Change detection is driven with falling and rising edges on enabled pins and with edges on disabled pins, and a pin-register read is made between steps to show that the flags clear and detection re-arms.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    REG_DIR  = 3'd0,
    REG_ALT  = 3'd1,
    REG_PORT = 3'd2,
    REG_ANA  = 3'd3,
    REG_IEN  = 3'd4,
    REG_PIN  = 3'd5
  } gpio_reg_e;

  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] stage_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < N; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[N-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] port_i,
  input  logic [W-1:0] ana_i,
  input  logic [W-1:0] periph_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_pu_o,
  output logic [W-1:0] pad_in_masked_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pad_oe_o[i]        = dir_i[i];
      pad_out_o[i]       = alt_i[i] ? periph_i[i] : port_i[i];
      // port bit doubles as pull-up enable on inputs
      pad_pu_o[i]        = ~dir_i[i] & port_i[i];
      // analog mode: digital input buffer off, reads 0
      pad_in_masked_o[i] = pad_in_i[i] & ~ana_i[i];
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] ien_i,
  input  logic         ack_i,
  output logic [W-1:0] flag_o,
  output logic         irq_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] diff;

  assign diff = (pin_i ^ snap_q) & ien_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      flag_q <= '0;
    end else if (ack_i) begin
      snap_q <= pin_i;
      flag_q <= '0;
    end else begin
      flag_q <= flag_q | diff;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |flag_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  input  logic [W-1:0]     pad_in_i,
  input  logic [W-1:0]     periph_out_i,
  output logic [W-1:0]     pad_out_o,
  output logic [W-1:0]     pad_oe_o,
  output logic [W-1:0]     pad_pu_o,
  output logic             irq_o
);
  logic [W-1:0] dir_q, alt_q, port_q, ana_q, ien_q;
  logic [W-1:0] pad_in_masked, pin_sync, chg_flag;
  logic         pin_ack;
  gpio_reg_e    wsel, rsel;

  assign wsel = gpio_reg_e'(wr_sel_i);
  assign rsel = gpio_reg_e'(rd_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      alt_q  <= '0;
      port_q <= '0;
      ana_q  <= '0;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wsel)
        REG_DIR:  dir_q  <= wr_data_i;
        REG_ALT:  alt_q  <= wr_data_i;
        REG_PORT: port_q <= wr_data_i;
        REG_ANA:  ana_q  <= wr_data_i;
        REG_IEN:  ien_q  <= wr_data_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      REG_DIR:  rd_data_o = dir_q;
      REG_ALT:  rd_data_o = alt_q;
      REG_PORT: rd_data_o = port_q;
      REG_ANA:  rd_data_o = ana_q;
      REG_IEN:  rd_data_o = ien_q;
      REG_PIN:  rd_data_o = pin_sync;
      default:  rd_data_o = '0;
    endcase
  end

  assign pin_ack = rd_en_i && (rsel == REG_PIN);

  gpio_pad_mux #(.W(W)) i_mux (
    .dir_i           (dir_q),
    .alt_i           (alt_q),
    .port_i          (port_q),
    .ana_i           (ana_q),
    .periph_i        (periph_out_i),
    .pad_in_i        (pad_in_i),
    .pad_out_o       (pad_out_o),
    .pad_oe_o        (pad_oe_o),
    .pad_pu_o        (pad_pu_o),
    .pad_in_masked_o (pad_in_masked)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_masked),
    .q_o    (pin_sync)
  );

  gpio_chg_detect #(.W(W)) i_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_sync),
    .ien_i  (ien_q),
    .ack_i  (pin_ack),
    .flag_o (chg_flag),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [2:0]   wr_sel_i,
  input logic [W-1:0] wr_data_i,
  input logic         rd_en_i,
  input logic [2:0]   rd_sel_i,
  input logic [W-1:0] rd_data_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] pad_pu_o,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] ana_q,
  input logic         irq_o
);
  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd0) |=> (pad_oe_o == $past(wr_data_i)));

  p_pu_inputs_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);

  p_analog_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 3'd5) |->
      ((rd_data_o & ana_q & $past(ana_q) & $past(ana_q, 2)) == '0));

  p_irq_needs_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(ien_q) != '0));

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == 3'd5) |=> !irq_o);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .pad_oe_o  (pad_oe_o),
  .pad_pu_o  (pad_pu_o),
  .ien_q     (ien_q),
  .ana_q     (ana_q),
  .irq_o     (irq_o)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [2:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic [7:0] pad_in_i = '0;
  logic [7:0] periph_out_i = '0;
  logic [7:0] pad_out_o, pad_oe_o, pad_pu_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_port_ctrl i_gpio_port_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
    #1;
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic peek(logic [2:0] sel, output logic [7:0] v);
    rd_sel_i = sel;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic rd_pin(output logic [7:0] v);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_sel_i = 3'd5;
    #1 v = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 pu", pad_pu_o, 8'h00);
    chk("R1 out", pad_out_o, 8'h00);
    chk("R1 irq", irq_o, 0);
    peek(3'd0, v); chk("R1 dir reg", v, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] v;
    wr(3'd0, 8'hFF);
    chk("R2 oe", pad_oe_o, 8'hFF);
    wr(3'd2, 8'hA5);
    chk("R3 out", pad_out_o, 8'hA5);
    chk("R5 pu off on outputs", pad_pu_o, 8'h00);
    peek(3'd2, v); chk("R11 port readback", v, 8'hA5);
  endtask

  task automatic t_alt();
    logic [7:0] v;
    periph_out_i = 8'h3C;
    wr(3'd1, 8'h0F);
    chk("R4 alt mux", pad_out_o, 8'hAC);
    peek(3'd1, v); chk("R11 alt readback", v, 8'h0F);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_pullup();
    wr(3'd0, 8'h0F);
    chk("R2 oe partial", pad_oe_o, 8'h0F);
    chk("R5 pu inputs", pad_pu_o, 8'hA0);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    chk("R5 pu cleared", pad_pu_o, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    @(negedge clk_i);
    pad_in_i = 8'h5A;
    step(1); peek(3'd5, v); chk("R6 one edge", v, 8'h00);
    step(1); peek(3'd5, v); chk("R6 two edges", v, 8'h5A);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    wr(3'd3, 8'hF0);
    @(negedge clk_i);
    pad_in_i = 8'hFF;
    step(3); peek(3'd5, v); chk("R7 analog reads 0", v, 8'h0F);
    peek(3'd3, v); chk("R11 ana readback", v, 8'hF0);
    wr(3'd3, 8'h00);
    @(negedge clk_i);
    pad_in_i = 8'h00;
    step(3);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    rd_pin(v);
    @(negedge clk_i); pad_in_i = 8'h08;
    step(4); chk("R10 disabled no irq", irq_o, 0);
    rd_pin(v); chk("R6 pin value", v, 8'h08);
    wr(3'd4, 8'hFF);
    step(2); chk("R8 no change no irq", irq_o, 0);
    @(negedge clk_i); pad_in_i = 8'h00;
    step(2); chk("R8 not before sync", irq_o, 0);
    step(1); chk("R8 falling raises irq", irq_o, 1);
    rd_pin(v); chk("R9 read value", v, 8'h00);
    chk("R9 irq cleared", irq_o, 0);
    step(2); chk("R9 stays clear", irq_o, 0);
    @(negedge clk_i); pad_in_i = 8'h40;
    step(3); chk("R8 rising raises irq", irq_o, 1);
    rd_pin(v);
    chk("R9 cleared again", irq_o, 0);
    wr(3'd4, 8'h01);
    @(negedge clk_i); pad_in_i = 8'hC0;
    step(4); chk("R10 masked pin", irq_o, 0);
    @(negedge clk_i); pad_in_i = 8'hC1;
    step(3); chk("R8 enabled pin", irq_o, 1);
    rd_pin(v);
    chk("R9 final clear", irq_o, 0);
  endtask

  task automatic t_pin_ro();
    logic [7:0] v;
    wr(3'd5, 8'h00);
    peek(3'd5, v); chk("R11 pin write ignored", v, 8'hC1);
    peek(3'd0, v); chk("R11 dir untouched", v, 8'h00);
    peek(3'd4, v); chk("R11 ien untouched", v, 8'h01);
  endtask

  initial begin
    #20 rst_ni = 1'b1;
    step(1);
    t_reset();
    t_output();
    t_alt();
    t_pullup();
    t_sync();
    t_analog();
    t_irq();
    t_pin_ro();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule